// File: doc/BRIEF.md
# Low-Order Interleaved Memory Controller

This block fronts a bank of `2^BANK_BITS` independent memory modules. Consecutive word addresses fall in consecutive modules. Each module is a small synchronous array that stays occupied for a fixed number of clock cycles after it is started. A single request port carries word addresses. A single response port returns each word together with the address it came from, in the order the requests were accepted.

The controller has two access modes.

- **Concurrent mode.** A request starts only the module it addresses. A new request may start a different module in the very next cycle, so module activity is staggered and the accesses overlap. A unit-stride stream therefore runs at one word per cycle.
- **Simultaneous mode.** A request starts every module at once on the same in-module word. The results are captured in a row of latches and then streamed out one per cycle, lowest module first.

The mode input is only honoured while nothing is in flight. Streams of either kind are kept internally consistent.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: For a request address x, the module index is x[BANK_BITS-1:0] and the in-module word index is x[ADDR_W-1:BANK_BITS]. There are 2^BANK_BITS modules.
- R2: While reset is held, the word stored at address x is loaded with ((x * 0x9E37) ^ 0x5A5A), truncated to DATA_W bits. Every response carries the data stored at its response address.
- R3: In concurrent mode (mode value 0), req_ready is high exactly when the addressed module is free. A module that starts in cycle c is busy in cycles c+1 through c+CYCLE_T-1 and free again in cycle c+CYCLE_T.
- R4: In concurrent mode, a request accepted in cycle c produces a response with its own address in cycle c+CYCLE_T. Requests to distinct modules may be accepted in back-to-back cycles, and their responses come out in acceptance order.
- R5: In simultaneous mode (mode value 1), req_ready is high exactly when the controller is idle. An accepted request starts all modules on its word index, and its module bits are ignored.
- R6: A simultaneous request with word index w accepted in cycle c produces responses in cycles c+CYCLE_T+k for k = 0 to 2^BANK_BITS-1. The response in cycle c+CYCLE_T+k carries address {w, k}.
- R7: The controller is idle in a cycle when no response is pending for that cycle or any later one. In an idle cycle, mode_sel takes effect in that same cycle. In any other cycle, mode_sel is ignored and the previous mode is kept.
- R8: After reset, rsp_valid is low, every module is free, and no response is pending.
- R9: At most one response is presented per cycle. A concurrent response and a simultaneous response never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 selects concurrent mode, 1 selects simultaneous mode; applied only while idle |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request word address |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | ADDR_W | Address of the returned word |
| rsp_data | output | DATA_W | Returned word |

## Verification
Two kinds of event can land in the same cycle, and the bench provokes both.

- **Response and re-issue to the same module.** A unit-stride stream makes a module emit its response in the same cycle that a request re-issues to that module. A fixed-module stream makes stalls and re-arms meet on a single module.
- **Last response and mode change.** In a random phase, mode_sel toggles while accesses are in flight, so a mode change can arrive in the cycle of the final pending response (ignored) or in the cycle just after it (taken).

A behavioural queue model predicts req_ready and the full response on every cycle, and any mismatch is reported.

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int BANK_BITS = 2,
  parameter int DATA_W    = 16,
  parameter int CYCLE_T   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sel,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int M      = 1 << BANK_BITS;
  localparam int WORD_W = ADDR_W - BANK_BITS;
  localparam int DEPTH  = 1 << WORD_W;
  localparam int CNT_W  = $clog2(CYCLE_T + 1);
  localparam int SL_W   = $clog2(M + 1);

  function automatic logic [DATA_W-1:0] seed_word(input logic [ADDR_W-1:0] a);
    logic [31:0] t;
    t = (32'(a) * 32'h9E37) ^ 32'h5A5A;
    return t[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] mem [M][DEPTH];
  logic [CNT_W-1:0]  busy [M];

  logic [CYCLE_T-1:0] pv;
  logic [ADDR_W-1:0]  pa [CYCLE_T];
  logic [DATA_W-1:0]  pd [CYCLE_T];

  logic [CNT_W-1:0]     s_wait;
  logic [SL_W-1:0]      s_left;
  logic [BANK_BITS-1:0] s_idx;
  logic [WORD_W-1:0]    s_word;
  logic [DATA_W-1:0]    blk [M];

  logic mode_q, mode_eff, idle, acc_c, acc_s;
  logic [BANK_BITS-1:0] req_bank;
  logic [WORD_W-1:0]    req_word;

  assign req_bank  = req_addr[BANK_BITS-1:0];
  assign req_word  = req_addr[ADDR_W-1:BANK_BITS];
  assign idle      = (pv == '0) && (s_wait == '0) && (s_left == '0);
  assign mode_eff  = idle ? mode_sel : mode_q;
  assign req_ready = mode_eff ? idle : (busy[req_bank] == '0);
  assign acc_c     = req_valid && req_ready && !mode_eff;
  assign acc_s     = req_valid && req_ready && mode_eff;

  assign rsp_valid = pv[CYCLE_T-1] || (s_left != '0);
  assign rsp_addr  = pv[CYCLE_T-1] ? pa[CYCLE_T-1] : {s_word, s_idx};
  assign rsp_data  = pv[CYCLE_T-1] ? pd[CYCLE_T-1] : blk[s_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      pv     <= '0;
      s_wait <= '0;
      s_left <= '0;
      s_idx  <= '0;
      s_word <= '0;
      for (int k = 0; k < M; k++) begin
        busy[k] <= '0;
        blk[k]  <= '0;
        for (int w = 0; w < DEPTH; w++)
          mem[k][w] <= seed_word(ADDR_W'((w << BANK_BITS) | k));
      end
      for (int i = 0; i < CYCLE_T; i++) begin
        pa[i] <= '0;
        pd[i] <= '0;
      end
    end else begin
      mode_q <= mode_eff;
      for (int k = 0; k < M; k++) begin
        if (acc_s || (acc_c && req_bank == BANK_BITS'(k)))
          busy[k] <= CNT_W'(CYCLE_T - 1);
        else if (busy[k] != '0)
          busy[k] <= busy[k] - 1'b1;
      end
      pv    <= {pv[CYCLE_T-2:0], acc_c};
      pa[0] <= req_addr;
      pd[0] <= mem[req_bank][req_word];
      for (int i = 1; i < CYCLE_T; i++) begin
        pa[i] <= pa[i-1];
        pd[i] <= pd[i-1];
      end
      if (s_left != '0) begin
        s_left <= s_left - 1'b1;
        s_idx  <= s_idx + 1'b1;
      end
      if (acc_s) begin
        s_wait <= CNT_W'(CYCLE_T - 1);
        s_word <= req_word;
        for (int k = 0; k < M; k++) blk[k] <= mem[k][req_word];
      end else if (s_wait != '0) begin
        s_wait <= s_wait - 1'b1;
        if (s_wait == CNT_W'(1)) begin
          s_left <= SL_W'(M);
          s_idx  <= '0;
        end
      end
    end
  end

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !idle |=> mode_q == $past(mode_q));

  p_s_busy_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !idle) |-> !req_ready);

  p_s_load_r6: assert property (@(posedge clk) disable iff (rst)
    (s_wait == CNT_W'(1)) |=> (s_left == SL_W'(M)) && (s_idx == '0));

  p_s_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (s_left != '0) |=> s_left == SL_W'($past(s_left) - 1'b1));

  p_one_source_r9: assert property (@(posedge clk) disable iff (rst)
    !(pv[CYCLE_T-1] && (s_left != '0)));

  p_c_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !idle && (busy[req_bank] != '0)) |-> !req_ready);
endmodule

// File: tb/test_ilv_mem_ctrl.sv
module test_ilv_mem_ctrl;
  localparam int ADDR_W = 8, BANK_BITS = 2, DATA_W = 16, CYCLE_T = 4;
  localparam int M = 1 << BANK_BITS;
  localparam int NCYC = 3000;

  logic clk = 0, rst = 1, mode_sel = 0, req_valid = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid;
  logic [ADDR_W-1:0] rsp_addr;
  logic [DATA_W-1:0] rsp_data;

  ilv_mem_ctrl #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .DATA_W(DATA_W), .CYCLE_T(CYCLE_T))
    i_ilv_mem_ctrl (.clk(clk), .rst(rst), .mode_sel(mode_sel), .req_valid(req_valid),
      .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_addr(rsp_addr), .rsp_data(rsp_data));

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;

  int q_due[$];
  int q_addr[$];
  int q_kind[$];
  int busy_until[M];
  bit mq;

  function automatic logic [DATA_W-1:0] exp_word(input int a);
    logic [31:0] t;
    t = (32'(a) * 32'h9E37) ^ 32'h5A5A;
    return t[DATA_W-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seq_addr;
    seq_addr = 0;
    mq = 0;
    for (int k = 0; k < M; k++) busy_until[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      bit idle, me, er, acc, ev;
      int bank;
      if (cyc < 300) begin
        mode_sel = 0; req_valid = 1; req_addr = ADDR_W'(seq_addr);
      end else if (cyc < 600) begin
        mode_sel = 0; req_valid = ($urandom % 4) != 0;
        req_addr = ADDR_W'((($urandom % 64) << BANK_BITS) | 1);
      end else if (cyc < 1000) begin
        mode_sel = 1; req_valid = 1; req_addr = ADDR_W'($urandom);
      end else begin
        if (($urandom % 8) == 0) mode_sel = ~mode_sel;
        req_valid = ($urandom % 10) < 7;
        req_addr = ADDR_W'(($urandom % 3 == 0) ? seq_addr : $urandom);
      end
      #1;
      if (cyc == 0) chk(rsp_valid === 1'b0, "R8 rsp_valid after reset", rsp_valid, 0);
      idle = (q_due.size() == 0);
      me = idle ? mode_sel : mq;
      bank = int'(req_addr) % M;
      er = me ? idle : (busy_until[bank] <= cyc);
      chk(req_ready === er,
          (idle && mode_sel != mq) ? "R7 ready after mode change" : (me ? "R5 ready in simultaneous mode" : "R3 ready in concurrent mode"),
          req_ready, er);
      ev = (q_due.size() != 0) && (q_due[0] == cyc);
      chk(rsp_valid === ev, "R9 rsp_valid", rsp_valid, ev);
      if (ev) begin
        chk(rsp_addr === ADDR_W'(q_addr[0]), q_kind[0] ? "R6 rsp_addr" : "R4 rsp_addr / R1", rsp_addr, q_addr[0]);
        chk(rsp_data === exp_word(q_addr[0]), "R2 rsp_data", rsp_data, exp_word(q_addr[0]));
        void'(q_due.pop_front()); void'(q_addr.pop_front()); void'(q_kind.pop_front());
      end
      acc = req_valid && er;
      if (acc) begin
        if (!me) begin
          busy_until[bank] = cyc + CYCLE_T;
          q_due.push_back(cyc + CYCLE_T); q_addr.push_back(int'(req_addr)); q_kind.push_back(0);
          seq_addr = (seq_addr + 1) % (1 << ADDR_W);
        end else begin
          for (int k = 0; k < M; k++) begin
            busy_until[k] = cyc + CYCLE_T;
            q_due.push_back(cyc + CYCLE_T + k);
            q_addr.push_back(((int'(req_addr) / M) * M) + k);
            q_kind.push_back(1);
          end
        end
      end
      mq = me;
      @(negedge clk);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule